// File: doc/BRIEF.md
# Lock-Driven Glitch-Free Master Clock Failover

This block chooses which clock drives the master clock of an audio receiver. In normal operation it forwards the clock recovered by a PLL. When the PLL reports that it has lost lock, the block hands the master clock over to a local oscillator. When lock comes back, it hands the clock back to the PLL. Every handover is break-before-make. The master clock holds low while no source owns it, so it never shows a runt pulse.

Failover is always active when the hardware-mode pin is high. In software mode it is active only while a control bit is set. When failover is off, the recovered clock always drives the output, even after it has slowed down because lock was lost. In serial master mode the block also divides the selected master clock to make the serial bit clock and the left/right frame clock. Both dividers restart from zero at every change of source. A status output reports which source owns the master clock.

Top module: `ckf_clock_failover`

## Requirements
- R1: During reset the oscillator drives `mck_o`, `src_pll_o` is 0 (0 = oscillator, 1 = PLL) and `bclk_o` and `lrclk_o` are 0.
- R2: With failover active, `mck_o` follows the PLL clock while lock is qualified, and it follows the oscillator clock while lock is not qualified.
- R3: In software mode (`hw_mode`=0) failover is active only when `sw_failover_en`=1. With the bit at 0, `mck_o` follows the PLL clock whatever `pll_locked` is.
- R4: In hardware mode (`hw_mode`=1) failover is active whatever the value of `sw_failover_en`.
- R5: `pll_locked` passes through a 2-flop synchronizer in the oscillator domain. A change takes effect only after the synchronized value has differed from the qualified value for 2 consecutive oscillator cycles, so a 1-cycle pulse has no effect.
- R6: `mck_o` is free of glitches. The two source enables are never high together, and no high or low phase of `mck_o` is shorter than the shorter half period of the two source clocks.
- R7: In serial master mode `bclk_o` is `mck_o` divided by 4 (50% duty) and `lrclk_o` is `bclk_o` divided by 64 (50% duty).
- R8: When `ser_master`=0, `bclk_o` and `lrclk_o` are held at 0.
- R9: `src_pll_o` changes on the first rising edge of `mck_o` from the new source. At that same edge both dividers clear. `bclk_o` first rises on the 2nd rising edge after it, and `lrclk_o` first rises on the 128th.
- R10: When failover is off and the PLL clock has slowed, the serial clocks are derived from that slow clock: the `bclk_o` period is 4 PLL periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local oscillator clock, also the reset and control domain |
| pll_clk | input | 1 | Clock recovered by the PLL |
| rst | input | 1 | Synchronous active-high reset, oscillator domain |
| pll_locked | input | 1 | PLL lock flag, asynchronous |
| sw_failover_en | input | 1 | Software failover enable bit |
| hw_mode | input | 1 | 1 = hardware mode (failover forced on) |
| ser_master | input | 1 | 1 = serial port is master, serial clocks driven |
| mck_o | output | 1 | Selected master clock |
| bclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Left/right frame clock |
| src_pll_o | output | 1 | Active source: 1 = PLL, 0 = oscillator |

## Verification
The assertions check on every cycle that the two source enables are exclusive, that the lock qualifier only flips after two agreeing synchronized samples, that a change of source clears both dividers and updates the status, and that the serial clocks stay low outside master mode. Some behaviour only the bench scenarios can show. These are the measured periods and duty of the master, bit and frame clocks on each source, the absence of short phases across every handover, the decisions made in software and hardware modes, and the slow-clock behaviour when failover is off.

// File: rtl/ckf_pkg.sv
package ckf_pkg;
  typedef enum logic {
    SRC_OSC = 1'b0,
    SRC_PLL = 1'b1
  } src_e;
endpackage

// File: rtl/ckf_sync.sv
// Multi-flop synchronizer; edge polarity selected by parameter.
module ckf_sync #(
  parameter int   STAGES   = 2,
  parameter bit   NEG_EDGE = 1'b0,
  parameter logic RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_pos
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ckf_lock_qual.sv
// Synchronizes the lock flag and requires a stable run before accepting it.
module ckf_lock_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 2
) (
  input  logic osc_clk,
  input  logic rst,
  input  logic pll_locked,
  input  logic sw_failover_en,
  input  logic hw_mode,
  output logic lock_s,
  output logic lock_ok,
  output logic want_pll
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [CW-1:0] run_cnt;
  logic          fo_active;

  ckf_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0), .RST_VAL(1'b0)) u_lock_sync (
    .clk(osc_clk), .rst(rst), .d(pll_locked), .q(lock_s)
  );

  assign fo_active = hw_mode | sw_failover_en;

  always_ff @(posedge osc_clk) begin
    if (rst) begin
      run_cnt <= '0;
      lock_ok <= 1'b0;
    end else if (lock_s == lock_ok) begin
      run_cnt <= '0;
    end else if (run_cnt == CW'(STABLE_CYC - 1)) begin
      run_cnt <= '0;
      lock_ok <= lock_s;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge osc_clk) begin
    if (rst) want_pll <= 1'b0;
    else     want_pll <= ~fo_active | lock_ok;
  end
endmodule

// File: rtl/ckf_gf_mux.sv
// Break-before-make clock selector with falling-edge enable chains.
module ckf_gf_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic pll_clk,
  input  logic rst,
  input  logic want_pll,
  output logic en_osc,
  output logic en_pll,
  output logic mck_o
);
  logic rst_pll;
  logic d_osc;
  logic d_pll;

  // Reset carried into the recovered-clock domain.
  ckf_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0), .RST_VAL(1'b1)) u_rst_pll (
    .clk(pll_clk), .rst(1'b0), .d(rst), .q(rst_pll)
  );

  assign d_osc = ~want_pll & ~en_pll;
  assign d_pll =  want_pll & ~en_osc;

  ckf_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1), .RST_VAL(1'b1)) u_en_osc (
    .clk(osc_clk), .rst(rst), .d(d_osc), .q(en_osc)
  );

  ckf_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1), .RST_VAL(1'b0)) u_en_pll (
    .clk(pll_clk), .rst(rst_pll), .d(d_pll), .q(en_pll)
  );

  assign mck_o = (osc_clk & en_osc) | (pll_clk & en_pll);
endmodule

// File: rtl/ckf_serial_div.sv
// Bit/frame clock dividers on the selected master clock, plus source status.
module ckf_serial_div
  import ckf_pkg::*;
#(
  parameter int BCLK_LOG2 = 2,
  parameter int LR_LOG2   = 6
) (
  input  logic mck,
  input  logic rst,
  input  logic pll_active,
  input  logic master,
  output logic bclk_o,
  output logic lrclk_o,
  output logic src_pll_o
);
  localparam int CW = BCLK_LOG2 + LR_LOG2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  src_e          src_q;
  src_e          src_now;
  logic          restart;

  assign src_now = pll_active ? SRC_PLL : SRC_OSC;
  assign restart = (src_now != src_q);
  assign cnt_nx  = restart ? '0 : cnt + 1'b1;

  always_ff @(posedge mck) begin
    if (rst) begin
      cnt     <= '0;
      src_q   <= SRC_OSC;
      bclk_o  <= 1'b0;
      lrclk_o <= 1'b0;
    end else begin
      cnt     <= cnt_nx;
      src_q   <= src_now;
      bclk_o  <= master & cnt_nx[BCLK_LOG2-1];
      lrclk_o <= master & cnt_nx[CW-1];
    end
  end

  assign src_pll_o = (src_q == SRC_PLL);
endmodule

// File: rtl/ckf_clock_failover.sv
module ckf_clock_failover #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 2,
  parameter int BCLK_LOG2   = 2,
  parameter int LR_LOG2     = 6
) (
  input  logic osc_clk,
  input  logic pll_clk,
  input  logic rst,
  input  logic pll_locked,
  input  logic sw_failover_en,
  input  logic hw_mode,
  input  logic ser_master,
  output logic mck_o,
  output logic bclk_o,
  output logic lrclk_o,
  output logic src_pll_o
);
  logic lock_s;
  logic lock_ok;
  logic want_pll;
  logic en_osc;
  logic en_pll;

  ckf_lock_qual #(.SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC)) u_qual (
    .osc_clk(osc_clk), .rst(rst), .pll_locked(pll_locked),
    .sw_failover_en(sw_failover_en), .hw_mode(hw_mode),
    .lock_s(lock_s), .lock_ok(lock_ok), .want_pll(want_pll)
  );

  ckf_gf_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .osc_clk(osc_clk), .pll_clk(pll_clk), .rst(rst), .want_pll(want_pll),
    .en_osc(en_osc), .en_pll(en_pll), .mck_o(mck_o)
  );

  ckf_serial_div #(.BCLK_LOG2(BCLK_LOG2), .LR_LOG2(LR_LOG2)) u_div (
    .mck(mck_o), .rst(rst), .pll_active(en_pll), .master(ser_master),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o), .src_pll_o(src_pll_o)
  );
endmodule

// File: rtl/ckf_clock_failover_chk.sv
module ckf_clock_failover_chk (
  input logic osc_clk,
  input logic mck_o,
  input logic rst,
  input logic hw_mode,
  input logic sw_failover_en,
  input logic ser_master,
  input logic lock_s,
  input logic lock_ok,
  input logic want_pll,
  input logic en_osc,
  input logic en_pll,
  input logic bclk_o,
  input logic lrclk_o,
  input logic src_pll_o
);
  assert_enables_exclusive_R6: assert property (
    @(posedge osc_clk) disable iff (rst) $onehot0({en_osc, en_pll}));

  assert_lock_two_samples_R5: assert property (
    @(posedge osc_clk) disable iff (rst)
    (lock_ok != $past(lock_ok)) |->
      ($past(lock_s) == lock_ok && $past(lock_s, 2) == lock_ok));

  assert_sw_disabled_keeps_pll_R3: assert property (
    @(posedge osc_clk) disable iff (rst)
    (!hw_mode && !sw_failover_en) |=> want_pll);

  assert_switch_restarts_R9: assert property (
    @(posedge mck_o) disable iff (rst)
    (en_pll != src_pll_o) |=>
      (src_pll_o == $past(en_pll) && !bclk_o && !lrclk_o));

  assert_slave_quiet_R8: assert property (
    @(posedge mck_o) disable iff (rst)
    !ser_master |=> (!bclk_o && !lrclk_o));
endmodule

bind ckf_clock_failover ckf_clock_failover_chk u_chk (
  .osc_clk(osc_clk), .mck_o(mck_o), .rst(rst), .hw_mode(hw_mode),
  .sw_failover_en(sw_failover_en), .ser_master(ser_master),
  .lock_s(lock_s), .lock_ok(lock_ok), .want_pll(want_pll),
  .en_osc(en_osc), .en_pll(en_pll), .bclk_o(bclk_o),
  .lrclk_o(lrclk_o), .src_pll_o(src_pll_o)
);

// File: tb/sim_ckf_clock_failover.sv
`timescale 1ns/1ps
module sim_ckf_clock_failover;
  logic osc_clk = 1'b0;
  logic pll_clk = 1'b0;
  logic rst = 1'b1;
  logic pll_locked = 1'b0;
  logic sw_failover_en = 1'b0;
  logic hw_mode = 1'b0;
  logic ser_master = 1'b1;
  logic mck_o, bclk_o, lrclk_o, src_pll_o;
  real  pll_half = 3.5;

  int checks = 0;
  int failures = 0;
  int glitches = 0;
  bit mon_on = 1'b0;
  real last_edge = 0.0;

  always #2.5 osc_clk = ~osc_clk;
  always #(pll_half) pll_clk = ~pll_clk;

  ckf_clock_failover u0 (
    .osc_clk(osc_clk), .pll_clk(pll_clk), .rst(rst), .pll_locked(pll_locked),
    .sw_failover_en(sw_failover_en), .hw_mode(hw_mode), .ser_master(ser_master),
    .mck_o(mck_o), .bclk_o(bclk_o), .lrclk_o(lrclk_o), .src_pll_o(src_pll_o)
  );

  // Shortest legal phase is the oscillator half period (2.5 ns).
  always @(mck_o) begin
    if (mon_on && ($realtime - last_edge) < 2.49) glitches++;
    last_edge = $realtime;
  end

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input real act, input real exp);
    chk((act - exp) < 0.05 && (exp - act) < 0.05, req, act, exp);
  endtask

  task automatic wait_osc(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  task automatic mck_period(output real p);
    real t0;
    @(posedge mck_o); t0 = $realtime;
    @(posedge mck_o); p = $realtime - t0;
  endtask

  task automatic bclk_period(output real p);
    real t0;
    @(posedge bclk_o); t0 = $realtime;
    @(posedge bclk_o); p = $realtime - t0;
  endtask

  initial begin
    #900000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    real p, t0;
    int n, nb, nl, highs;

    // R1: reset state
    wait_osc(20);
    #1;
    chk(src_pll_o == 1'b0, "R1 status in reset", src_pll_o, 0);
    chk(bclk_o == 1'b0 && lrclk_o == 1'b0, "R1 serial clocks in reset", bclk_o | lrclk_o, 0);
    mck_period(p);
    chk_near("R1 mck from oscillator in reset", p, 5.0);

    @(negedge osc_clk);
    rst = 1'b0;
    sw_failover_en = 1'b1;
    wait_osc(10);
    mon_on = 1'b1;
    wait_osc(40);
    #1;
    chk(src_pll_o == 1'b0, "R2 unlocked stays on oscillator", src_pll_o, 0);

    // R2: lock arrives
    pll_locked = 1'b1;
    wait_osc(60);
    #1;
    chk(src_pll_o == 1'b1, "R2 locked selects pll", src_pll_o, 1);
    mck_period(p);
    chk_near("R2 mck period on pll", p, 7.0);

    // R7: divider ratios and duty
    bclk_period(p);
    chk_near("R7 bclk period", p, 28.0);
    @(posedge lrclk_o); t0 = $realtime;
    @(negedge lrclk_o);
    chk_near("R7 lrclk high time", $realtime - t0, 896.0);
    @(posedge lrclk_o);
    chk_near("R7 lrclk period", $realtime - t0, 1792.0);

    // R9: restart after lock loss
    @(negedge osc_clk);
    pll_locked = 1'b0;
    @(src_pll_o);
    n = 0; nb = 0; nl = 0;
    while (nl == 0 && n < 400) begin
      @(posedge mck_o); #0.5;
      n++;
      if (nb == 0 && bclk_o) nb = n;
      if (nl == 0 && lrclk_o) nl = n;
    end
    chk(nb == 2, "R9 first bclk rise after switch", nb, 2);
    chk(nl == 128, "R9 first lrclk rise after switch", nl, 128);
    chk(src_pll_o == 1'b0, "R2 lock loss selects oscillator", src_pll_o, 0);
    mck_period(p);
    chk_near("R2 mck period on oscillator", p, 5.0);

    // R5: single-cycle lock pulse ignored
    @(negedge osc_clk); pll_locked = 1'b1;
    @(negedge osc_clk); pll_locked = 1'b0;
    wait_osc(40);
    #1;
    chk(src_pll_o == 1'b0, "R5 one-cycle lock pulse ignored", src_pll_o, 0);

    // R3: software mode, failover bit cleared
    @(negedge osc_clk); sw_failover_en = 1'b0;
    wait_osc(60);
    #1;
    chk(src_pll_o == 1'b1, "R3 failover off keeps pll unlocked", src_pll_o, 1);
    mck_period(p);
    chk_near("R3 mck period on pll", p, 7.0);

    // R10: free-running slow pll clock
    pll_half = 20.0;
    wait_osc(60);
    mck_period(p);
    chk_near("R10 mck follows slow pll", p, 40.0);
    bclk_period(p);
    chk_near("R10 bclk from slow pll", p, 160.0);

    // R4: hardware mode forces failover
    @(negedge osc_clk); hw_mode = 1'b1;
    wait_osc(120);
    #1;
    chk(src_pll_o == 1'b0, "R4 hw mode fails over", src_pll_o, 0);
    mck_period(p);
    chk_near("R4 mck on oscillator", p, 5.0);
    pll_half = 3.5;
    wait_osc(20);
    @(negedge osc_clk); pll_locked = 1'b1;
    wait_osc(80);
    #1;
    chk(src_pll_o == 1'b1, "R4 hw mode relocks to pll", src_pll_o, 1);

    // R8: slave mode quiets serial clocks
    @(negedge osc_clk); ser_master = 1'b0;
    wait_osc(10);
    highs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge osc_clk);
      if (bclk_o || lrclk_o) highs++;
    end
    chk(highs == 0, "R8 serial clocks held low", highs, 0);

    // R6: no short phase across all handovers
    chk(glitches == 0, "R6 no runt phase on mck", glitches, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule